// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Byte Cache

This block sits between a processor request port and a main-memory port that moves whole 4-byte blocks. Every processor access reads or writes one byte at a 24-bit byte address. A set holds two lines. Each line carries a tag, a valid flag, a dirty flag and a recency flag. Both tags of the selected set are compared together. A hit is served from the cache. A miss picks a victim line, writes it back to memory first if it is dirty, then loads the wanted block. A write miss allocates the block and then merges the byte into it.

The set count is a parameter, `SET_W` (default 10). With `SET_W = 13` the cache holds 8192 sets and 64 KB, and the address splits into a 9-bit tag, a 13-bit set and a 2-bit byte lane. The cache takes one access at a time over a valid/ready handshake and answers with a one-cycle response pulse. Two running counters, accesses and hits, let the user work out the hit ratio.

Top module: `cache_2way`

## Requirements
- R1: A byte address splits, from the top down, into a tag of 24-2-SET_W bits, a SET_W-bit set index and a 2-bit lane. The memory port carries the 22-bit block address {tag, set}. With SET_W=13, byte address 16339C is block 058CE7 (tag 02C, set 0CE7), and 008004 is block 002001 (tag 001, set 0001).
- R2: An access hits when a valid line of its set holds a matching tag. The response then carries hit=1, and the access makes no memory request.
- R3: On a miss, the cache issues one memory read of the requested block before it responds, and the response carries hit=0. Memory requests only occur while the cache is busy.
- R4: Lane n of a block is bits 8n+7..8n. A read returns the byte in lane addr[1:0] of the current block contents.
- R5: A write hit updates only the cached byte, marks the line dirty and makes no memory write.
- R6: Replacement: an invalid way 0 is filled first, then an invalid way 1. When both lines are valid, the line whose recency flag is 0 is evicted. Every access sets the recency flag of the line it touches and clears the flag of the other line in the set.
- R7: A dirty victim is written back, with its full block at its own block address, before the fill read starts. A clean victim causes no memory write.
- R8: A write miss fetches the block, merges the byte into its lane, keeps the other three bytes from memory and leaves the line dirty.
- R9: `cpu_req_ready` is high only when the cache is idle, and it drops after an access is accepted. `cpu_resp_valid` is a single-cycle pulse for each accepted access.
- R10: `access_count` rises by one with each response, and `hit_count` rises by one with each hit response. Neither counter changes at any other time.
- R11: Reset clears every valid, dirty and recency flag and both counters, and leaves the cache idle with no memory request.
- R12: A memory request holds its valid, direction and address steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor access request |
| cpu_req_ready | output | 1 | Cache idle, request accepted this cycle |
| cpu_req_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_req_addr | input | ADDR_W (24) | Byte address |
| cpu_req_wdata | input | 8 | Byte to write |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | 8 | Byte read (write data echoed on writes) |
| cpu_resp_hit | output | 1 | 1 when the access hit |
| mem_req_valid | output | 1 | Memory request held until acknowledged |
| mem_req_we | output | 1 | 1 = write-back, 0 = block fetch |
| mem_req_addr | output | ADDR_W-2 (22) | Block address |
| mem_req_wdata | output | 32 | Block written back |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rdata | input | 32 | Fetched block, valid with mem_ack |
| access_count | output | CNT_W (32) | Responses given since reset |
| hit_count | output | CNT_W (32) | Hit responses since reset |

## Verification
Directed sequences aim three or more blocks at one set, so each outcome points to a single rule. A conflicting refetch separates a clean eviction from a dirty one. The written-back block address and data show that a write-back kept the stored tag and the modified lane. Reading the neighbouring lanes after a write miss separates a correct merge from a clobbered block. Random traffic uses four tags over four sets, including set 0 and the top set, with mixed reads and writes. Under this load the recency choice, the write-back ordering and the byte data are all checked against a golden byte image and an independent model of set contents.

// File: rtl/cache_pkg.sv
// Package: shared state encoding and byte-lane helpers for the two-way cache.
// Assumes 4-byte blocks with lane n at bits 8n+7..8n.
package cache_pkg;

    localparam int BLK_W  = 32;
    localparam int LANE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WB   = 2'd2,
        ST_FILL = 2'd3
    } cache_state_t;

    // Replace one byte lane of a block.
    function automatic logic [BLK_W-1:0] lane_merge(input logic [BLK_W-1:0] blk,
                                                    input logic [LANE_W-1:0] lane,
                                                    input logic [7:0] b);
        logic [BLK_W-1:0] r;
        r = blk;
        r[{lane, 3'b000} +: 8] = b;
        return r;
    endfunction

    // Extract one byte lane of a block.
    function automatic logic [7:0] lane_pick(input logic [BLK_W-1:0] blk,
                                             input logic [LANE_W-1:0] lane);
        return blk[{lane, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/cache_way_store.sv
// Module: storage for one way. Holds tag, data, valid, dirty and recency flag
// per set. Reads are combinational. Flags reset synchronously; tags and data do not.
module cache_way_store #(
    parameter int SET_W = 10,
    parameter int TAG_W = 12,
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic             rd_use,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_data,
    input  logic             wr_dirty,
    input  logic             use_en,
    input  logic             use_val
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [SETS-1:0]  use_q;
    logic [TAG_W-1:0] tag_mem  [SETS];
    logic [BLK_W-1:0] data_mem [SETS];

    // Read the addressed set.
    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_use   = use_q[rd_set];
    assign rd_tag   = tag_mem[rd_set];
    assign rd_data  = data_mem[rd_set];

    // Flag update: line write sets valid and dirty; recency written on touch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            use_q   <= '0;
        end else begin
            if (wr_en) begin
                valid_q[rd_set] <= 1'b1;
                dirty_q[rd_set] <= wr_dirty;
            end
            if (use_en) begin
                use_q[rd_set] <= use_val;
            end
        end
    end

    // Payload update: tag and block on line write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[rd_set]  <= wr_tag;
            data_mem[rd_set] <= wr_data;
        end
    end

endmodule

// File: rtl/cache_pick.sv
// Module: compares both tags of a set and chooses the victim line.
// Assumes the two lines never hold the same valid tag.
module cache_pick #(
    parameter int TAG_W = 12
) (
    input  logic [1:0]       line_valid,
    input  logic [1:0]       line_use,
    input  logic [TAG_W-1:0] tag0,
    input  logic [TAG_W-1:0] tag1,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             victim_way
);
    logic match0;
    logic match1;

    // Parallel compare of both ways.
    always_comb begin
        match0  = line_valid[0] && (tag0 == req_tag);
        match1  = line_valid[1] && (tag1 == req_tag);
        hit     = match0 || match1;
        hit_way = match1;
    end

    // Victim order: empty way 0, empty way 1, then the less recent line.
    always_comb begin
        if (!line_valid[0])      victim_way = 1'b0;
        else if (!line_valid[1]) victim_way = 1'b1;
        else if (!line_use[0])   victim_way = 1'b0;
        else                     victim_way = 1'b1;
    end

endmodule

// File: rtl/cache_stats.sv
// Module: access and hit counters, advanced once per response.
module cache_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             evt_hit,
    output logic [CNT_W-1:0] access_count,
    output logic [CNT_W-1:0] hit_count
);
    // Count responses and the hits among them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            access_count <= '0;
            hit_count    <= '0;
        end else if (evt) begin
            access_count <= access_count + 1'b1;
            if (evt_hit) hit_count <= hit_count + 1'b1;
        end
    end

endmodule

// File: rtl/cache_2way.sv
// Module: two-way set-associative write-back, write-allocate byte cache.
// Takes one request at a time. The sequence is lookup, then an optional
// write-back of the victim, then a fill, then a one-cycle response.
// Assumes the memory answers each request with a single-cycle mem_ack.
module cache_2way
    import cache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 10,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [7:0]        cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [7:0]        cpu_resp_rdata,
    output logic              cpu_resp_hit,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-3:0] mem_req_addr,
    output logic [BLK_W-1:0]  mem_req_wdata,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rdata,
    output logic [CNT_W-1:0]  access_count,
    output logic [CNT_W-1:0]  hit_count
);
    localparam int TAG_W = ADDR_W - SET_W - LANE_W;
    localparam int NWAYS = 2;

    cache_state_t      state;
    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [7:0]        req_wdata_q;
    logic              vic_q;
    logic              resp_valid_q;
    logic [7:0]        resp_rdata_q;
    logic              resp_hit_q;

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [LANE_W-1:0] lane;

    logic [NWAYS-1:0]  w_valid, w_dirty, w_use, way_wr_en;
    logic [TAG_W-1:0]  w_tag  [NWAYS];
    logic [BLK_W-1:0]  w_data [NWAYS];

    logic              hit, hit_way, victim_way;
    logic              wr_any, wr_way, wr_dirty_c, touch_en, touch_way;
    logic [BLK_W-1:0]  wr_data_c;
    logic              resp_load, resp_hit_c;
    logic [7:0]        resp_rdata_c;

    // Address fields of the request held in the latch.
    assign set_idx = req_addr_q[SET_W+LANE_W-1:LANE_W];
    assign req_tag = req_addr_q[ADDR_W-1:SET_W+LANE_W];
    assign lane    = req_addr_q[LANE_W-1:0];

    for (genvar g = 0; g < NWAYS; g++) begin : gen_way
        assign way_wr_en[g] = wr_any && (wr_way == 1'(g));
        cache_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_set   (set_idx),
            .rd_valid (w_valid[g]),
            .rd_dirty (w_dirty[g]),
            .rd_use   (w_use[g]),
            .rd_tag   (w_tag[g]),
            .rd_data  (w_data[g]),
            .wr_en    (way_wr_en[g]),
            .wr_tag   (req_tag),
            .wr_data  (wr_data_c),
            .wr_dirty (wr_dirty_c),
            .use_en   (touch_en),
            .use_val  (touch_way == 1'(g))
        );
    end

    cache_pick #(.TAG_W(TAG_W)) u_pick (
        .line_valid (w_valid),
        .line_use   (w_use),
        .tag0       (w_tag[0]),
        .tag1       (w_tag[1]),
        .req_tag    (req_tag),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    cache_stats #(.CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (resp_load),
        .evt_hit      (resp_hit_c),
        .access_count (access_count),
        .hit_count    (hit_count)
    );

    // Line write, recency update and response data for hit and fill completion.
    always_comb begin
        wr_any       = 1'b0;
        wr_way       = 1'b0;
        wr_data_c    = w_data[0];
        wr_dirty_c   = 1'b0;
        touch_en     = 1'b0;
        touch_way    = 1'b0;
        resp_load    = 1'b0;
        resp_hit_c   = 1'b0;
        resp_rdata_c = req_wdata_q;
        if (state == ST_LOOK && hit) begin
            wr_any     = req_we_q;
            wr_way     = hit_way;
            wr_data_c  = lane_merge(w_data[hit_way], lane, req_wdata_q);
            wr_dirty_c = 1'b1;
            touch_en   = 1'b1;
            touch_way  = hit_way;
            resp_load  = 1'b1;
            resp_hit_c = 1'b1;
            if (!req_we_q) resp_rdata_c = lane_pick(w_data[hit_way], lane);
        end else if (state == ST_FILL && mem_ack) begin
            wr_any     = 1'b1;
            wr_way     = vic_q;
            wr_data_c  = req_we_q ? lane_merge(mem_rdata, lane, req_wdata_q) : mem_rdata;
            wr_dirty_c = req_we_q;
            touch_en   = 1'b1;
            touch_way  = vic_q;
            resp_load  = 1'b1;
            if (!req_we_q) resp_rdata_c = lane_pick(mem_rdata, lane);
        end
    end

    // Control sequence and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            req_we_q     <= 1'b0;
            req_addr_q   <= '0;
            req_wdata_q  <= '0;
            vic_q        <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
            resp_hit_q   <= 1'b0;
        end else begin
            resp_valid_q <= resp_load;
            if (resp_load) begin
                resp_rdata_q <= resp_rdata_c;
                resp_hit_q   <= resp_hit_c;
            end
            case (state)
                ST_IDLE: if (cpu_req_valid) begin
                    req_we_q    <= cpu_req_we;
                    req_addr_q  <= cpu_req_addr;
                    req_wdata_q <= cpu_req_wdata;
                    state       <= ST_LOOK;
                end
                ST_LOOK: if (hit) begin
                    state <= ST_IDLE;
                end else begin
                    vic_q <= victim_way;
                    state <= (w_valid[victim_way] && w_dirty[victim_way]) ? ST_WB : ST_FILL;
                end
                ST_WB:   if (mem_ack) state <= ST_FILL;
                default: if (mem_ack) state <= ST_IDLE;
            endcase
        end
    end

    // Port drive.
    assign cpu_req_ready  = (state == ST_IDLE);
    assign cpu_resp_valid = resp_valid_q;
    assign cpu_resp_rdata = resp_rdata_q;
    assign cpu_resp_hit   = resp_hit_q;
    assign mem_req_valid  = (state == ST_WB) || (state == ST_FILL);
    assign mem_req_we     = (state == ST_WB);
    assign mem_req_addr   = (state == ST_WB) ? {w_tag[vic_q], set_idx} : {req_tag, set_idx};
    assign mem_req_wdata  = w_data[vic_q];

endmodule

// File: rtl/cache_2way_chk.sv
// Module: protocol and counter checks for cache_2way, attached by bind.
module cache_2way_chk #(
    parameter int BLK_AW = 22,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_we,
    input logic [BLK_AW-1:0] mem_req_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  access_count,
    input logic [CNT_W-1:0]  hit_count
);
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) cpu_req_valid && cpu_req_ready |=> !cpu_req_ready); // R9
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cpu_resp_valid |=> !cpu_resp_valid); // R9
    AST_MEM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> !cpu_req_ready); // R3
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R12
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid && mem_req_we && mem_ack |=> mem_req_valid && !mem_req_we); // R7
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n) cpu_resp_valid |-> access_count == $past(access_count) + CNT_W'(1)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cpu_resp_valid |-> $stable(access_count) && $stable(hit_count)); // R10
    AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) hit_count <= access_count); // R10
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> access_count == '0 && hit_count == '0 && !cpu_resp_valid); // R11
endmodule

bind cache_2way cache_2way_chk #(.BLK_AW(ADDR_W - 2), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_we     (mem_req_we),
    .mem_req_addr   (mem_req_addr),
    .mem_ack        (mem_ack),
    .access_count   (access_count),
    .hit_count      (hit_count)
);

// File: tb/sim_cache_2way.sv
// Bench: directed conflict sequences plus seeded random traffic, checked
// against a golden byte image and an independent set-contents model.
module sim_cache_2way;
    localparam int ADDR_W = 24;
    localparam int SET_W  = 13;
    localparam int CNT_W  = 32;
    localparam int LAT    = 3;
    localparam int SETS   = 1 << SET_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              cpu_req_valid, cpu_req_ready, cpu_req_we;
    logic [ADDR_W-1:0] cpu_req_addr;
    logic [7:0]        cpu_req_wdata;
    logic              cpu_resp_valid, cpu_resp_hit;
    logic [7:0]        cpu_resp_rdata;
    logic              mem_req_valid, mem_req_we;
    logic [ADDR_W-3:0] mem_req_addr;
    logic [31:0]       mem_req_wdata;
    logic              mem_ack;
    logic [31:0]       mem_rdata;
    logic [CNT_W-1:0]  access_count, hit_count;

    cache_2way #(.ADDR_W(ADDR_W), .SET_W(SET_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata), .cpu_resp_hit(cpu_resp_hit),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .access_count(access_count), .hit_count(hit_count)
    );

    int checks = 0;
    int errors = 0;
    int n_acc  = 0;
    int n_hit  = 0;
    int n_rd   = 0;
    int n_wr   = 0;
    logic [21:0] last_rd_blk, last_wr_blk;
    logic [31:0] last_wr_data;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Initial memory pattern per block.
    function automatic logic [31:0] blk_init(input int b);
        return (b * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    logic [31:0] mstore [int];
    logic [7:0]  gold   [int];

    function automatic logic [31:0] mem_get(input int b);
        if (mstore.exists(b)) return mstore[b];
        return blk_init(b);
    endfunction

    function automatic logic [7:0] gold_get(input int a);
        logic [31:0] w;
        if (gold.exists(a)) return gold[a];
        w = blk_init(a >> 2);
        return w[(a % 4) * 8 +: 8];
    endfunction

    // Fixed-latency memory: one-cycle ack after LAT waiting cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req_valid) begin
            if (mem_cnt == LAT) begin
                mem_cnt = 0;
                mem_ack <= 1'b1;
                if (mem_req_we) begin
                    mstore[int'(mem_req_addr)] = mem_req_wdata;
                    last_wr_blk  = mem_req_addr;
                    last_wr_data = mem_req_wdata;
                    n_wr++;
                end else begin
                    mem_rdata  <= mem_get(int'(mem_req_addr));
                    last_rd_blk = mem_req_addr;
                    n_rd++;
                end
            end else begin
                mem_cnt++;
            end
        end
    end
    int mem_cnt = 0;

    // Independent model of set contents.
    bit         mv [SETS][2];
    bit         mu [SETS][2];
    logic [8:0] mt [SETS][2];

    task automatic model_access(input logic [23:0] a, output bit hit, output bit wb, output logic [21:0] wb_blk);
        int s;
        int w;
        logic [8:0] t;
        s = int'(a[14:2]);
        t = a[23:15];
        wb = 1'b0;
        wb_blk = '0;
        if (mv[s][0] && mt[s][0] == t) begin hit = 1'b1; w = 0; end
        else if (mv[s][1] && mt[s][1] == t) begin hit = 1'b1; w = 1; end
        else begin
            hit = 1'b0;
            if (!mv[s][0]) w = 0;
            else if (!mv[s][1]) w = 1;
            else if (!mu[s][0]) w = 0;
            else w = 1;
            if (mv[s][w] && md[s][w]) begin wb = 1'b1; wb_blk = {mt[s][w], a[14:2]}; end
            mv[s][w] = 1'b1;
            mt[s][w] = t;
            md[s][w] = 1'b0;
        end
        mu[s][w]     = 1'b1;
        mu[s][1 - w] = 1'b0;
        if (cpu_req_we) md[s][w] = 1'b1;
    endtask
    bit md [SETS][2];

    // One handshake access; returns hit flag and byte.
    task automatic access(input bit we, input logic [23:0] a, input logic [7:0] d, output bit hit, output logic [7:0] rd);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = we;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_resp_valid) @(negedge clk);
        hit = cpu_resp_hit;
        rd  = cpu_resp_rdata;
    endtask

    // Access with full checking of hit, data and memory traffic.
    task automatic run_one(input bit we, input logic [23:0] a, input logic [7:0] d);
        bit e_hit, e_wb, got_hit;
        logic [21:0] e_wb_blk;
        logic [7:0] e_rd, got_rd;
        int rd0, wr0;
        cpu_req_we = we;
        model_access(a, e_hit, e_wb, e_wb_blk);
        e_rd = gold_get(int'(a));
        if (we) gold[int'(a)] = d;
        rd0 = n_rd;
        wr0 = n_wr;
        access(we, a, d, got_hit, got_rd);
        n_acc++;
        if (e_hit) n_hit++;
        check(got_hit == e_hit, "R2/R6 hit flag", 32'(got_hit), 32'(e_hit));
        if (!we) check(got_rd == e_rd, "R4 read byte", 32'(got_rd), 32'(e_rd));
        check(n_rd - rd0 == (e_hit ? 0 : 1), "R3 fetch count", 32'(n_rd - rd0), e_hit ? 32'd0 : 32'd1);
        check(n_wr - wr0 == int'(e_wb), "R5/R7 write-back count", 32'(n_wr - wr0), 32'(e_wb));
        if (e_wb) check(last_wr_blk == e_wb_blk, "R7 write-back address", 32'(last_wr_blk), 32'(e_wb_blk));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_up();
    end

    initial begin
        logic [23:0] a1, a2;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        cpu_req_valid = 1'b0;
        cpu_req_we = 1'b0;
        cpu_req_addr = '0;
        cpu_req_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle, no traffic, counters zero
        check(cpu_req_ready == 1'b1, "R11 ready after reset", 32'(cpu_req_ready), 32'd1);
        check(!cpu_resp_valid && !mem_req_valid, "R11 quiet after reset", 32'({cpu_resp_valid, mem_req_valid}), 32'd0);
        check(access_count == 0 && hit_count == 0, "R11 counters", access_count, 32'd0);

        // R1: address split seen on the memory port
        run_one(1'b0, 24'h16339C, 8'h00);
        check(last_rd_blk == 22'h058CE7, "R1 block of 16339C", 32'(last_rd_blk), 32'h058CE7);
        run_one(1'b0, 24'h16339C, 8'h00);
        run_one(1'b1, 24'h16339D, 8'hA5);
        run_one(1'b0, 24'h008004, 8'h00);
        check(last_rd_blk == 22'h002001, "R1 block of 008004", 32'(last_rd_blk), 32'h002001);

        // R6/R7: conflict set 0CE7 with a clean and then a dirty victim
        a1 = {9'h001, 13'h0CE7, 2'b00};
        a2 = {9'h002, 13'h0CE7, 2'b00};
        run_one(1'b0, a1, 8'h00);
        run_one(1'b0, 24'h16339C, 8'h00);
        run_one(1'b0, a2, 8'h00);
        run_one(1'b0, a1, 8'h00);
        check(last_wr_blk == 22'h058CE7, "R7 dirty line written back", 32'(last_wr_blk), 32'h058CE7);
        check(last_wr_data[15:8] == 8'hA5, "R7 written-back lane", 32'(last_wr_data[15:8]), 32'hA5);
        run_one(1'b0, 24'h16339D, 8'h00);

        // R8: write miss allocates and merges into lane 3
        run_one(1'b1, 24'h7FFFFF, 8'h3C);
        run_one(1'b0, 24'h7FFFFF, 8'h00);
        run_one(1'b0, 24'h7FFFFE, 8'h00);
        run_one(1'b0, 24'h7FFFFC, 8'h00);

        // Random traffic: four tags over four sets, mixed reads and writes
        for (int i = 0; i < 3000; i++) begin
            logic [12:0] s;
            logic [8:0]  t;
            logic [1:0]  pick;
            pick = 2'($urandom % 4);
            case (pick)
                2'd0: s = 13'h0000;
                2'd1: s = 13'h0001;
                2'd2: s = 13'h0CE7;
                default: s = 13'h1FFF;
            endcase
            t = 9'($urandom % 4);
            run_one(($urandom % 10) < 4, {t, s, 2'($urandom % 4)}, 8'($urandom));
        end

        @(negedge clk);
        check(access_count == 32'(n_acc), "R10 access counter", access_count, 32'(n_acc));
        check(hit_count == 32'(n_hit), "R10 hit counter", hit_count, 32'(n_hit));
        finish_up();
    end

endmodule